// File: doc/BRIEF.md
# Age-Ordered Redirect Filter

The filter sits at the back end of an out-of-order core. Several back-end sources raise redirect requests, for example on branch mispredictions or other squash causes. Each request names a thread and gives the sequence number of the instruction that caused it, a misprediction flag and a target address. For every thread the block keeps a marker: the sequence number of the youngest instruction still valid in the reorder buffer.

A request is only meaningful if its instruction is older than that marker. A request that refers to an instruction already squashed away is discarded. All requests that arrive in one cycle are compared combinationally. For each thread, the oldest eligible request wins and is broadcast one cycle later as a squash-until sequence number, together with its misprediction flag and target. Accepting a squash pulls the thread's marker back to the squashing instruction. Instructions inserted from rename advance the marker.

Sequence numbers are compared as unsigned magnitudes. The design assumes they do not wrap within the window of the reorder buffer.

Top module: `redirect_filter`

## Requirements
- R1: After reset, no thread broadcasts a redirect, and every thread's youngest-valid marker reads 0.
- R2: An insert for a thread whose sequence number is larger than that thread's marker sets the marker to that number. The new value is visible on `youngSeq` one cycle later.
- R3: An insert whose sequence number is not larger than the marker leaves the marker unchanged.
- R4: A request whose sequence number is strictly smaller than its thread's marker is broadcast one cycle later on that thread's outputs. The broadcast carries `sqValid` high and the request's sequence number, misprediction flag and target.
- R5: A request whose sequence number is equal to or larger than its thread's marker is dropped: there is no broadcast, and the marker does not change.
- R6: An accepted squash sets the thread's marker to the squashing sequence number. This takes priority over an insert for the same thread in the same cycle.
- R7: When several eligible requests target one thread in one cycle, the one with the smallest sequence number is broadcast. On equal sequence numbers, the lowest source index wins.
- R8: Each thread is filtered against its own marker only. Different threads can broadcast in the same cycle.
- R9: A broadcast lasts exactly one cycle. With no new accepted request, `sqValid` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| insValid | input | NUM_THREADS | Per-thread insert strobe from rename |
| insSeq | input | NUM_THREADS*SEQ_W | Largest inserted sequence number per thread (thread t at bits t*SEQ_W) |
| srcValid | input | NUM_SRC | Redirect request valid per source |
| srcTid | input | NUM_SRC*TID_W | Thread of each request |
| srcSeq | input | NUM_SRC*SEQ_W | Sequence number of the causing instruction |
| srcMispred | input | NUM_SRC | Request is a branch misprediction |
| srcTarget | input | NUM_SRC*ADDR_W | Redirect target address |
| sqValid | output | NUM_THREADS | Broadcast strobe per thread |
| sqSeq | output | NUM_THREADS*SEQ_W | Squash-until sequence number |
| sqMispred | output | NUM_THREADS | Misprediction flag of the broadcast |
| sqTarget | output | NUM_THREADS*ADDR_W | Target of the broadcast |
| youngSeq | output | NUM_THREADS*SEQ_W | Current youngest-valid marker per thread |

## Verification
Requests and inserts presented in one cycle show their effect after exactly one register stage. Both the broadcast fields and the updated marker appear after the next rising edge. The bench drives each cycle's inputs on the falling edge and computes the expected broadcast and marker from its own marker model. It compares them on the following falling edge, so every check samples the outputs exactly one cycle after the stimulus that caused them. The R9 check samples one further cycle later, with idle inputs.

// File: rtl/redirect_filter_pkg.sv
package redirect_filter_pkg;
  // per-thread strobes from control to datapath
  typedef struct packed {
    logic take;   // accept a redirect this cycle
    logic bump;   // advance marker from insert
  } strobe_t;
endpackage

// File: rtl/redirect_filter_ctrl.sv
module redirect_filter_ctrl
  import redirect_filter_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int NUM_SRC     = 3,
  parameter int SEQ_W       = 16,
  parameter int TID_W       = 1,
  parameter int IDX_W       = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [NUM_SRC-1:0]                  srcValid,
  input  logic [NUM_SRC-1:0][TID_W-1:0]       srcTid,
  input  logic [NUM_SRC-1:0][SEQ_W-1:0]       srcSeq,
  input  logic [NUM_THREADS-1:0]              insValid,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   insSeq,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   marker,
  output strobe_t [NUM_THREADS-1:0]           stb,
  output logic [NUM_THREADS-1:0][IDX_W-1:0]   win
);
  logic [NUM_THREADS-1:0][NUM_SRC-1:0] eligible;

  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        eligible[t][s] = srcValid[s] && (srcTid[s] == TID_W'(t)) &&
                         (srcSeq[s] < marker[t]);
      end
    end
  end

  // oldest eligible request per thread; strict compare keeps the lowest index on ties
  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      logic             found;
      logic [SEQ_W-1:0] best;
      logic [IDX_W-1:0] idx;
      found = 1'b0;
      best  = '1;
      idx   = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (eligible[t][s] && (!found || srcSeq[s] < best)) begin
          found = 1'b1;
          best  = srcSeq[s];
          idx   = IDX_W'(s);
        end
      end
      stb[t].take = found;
      stb[t].bump = insValid[t] && !found && (insSeq[t] > marker[t]);
      win[t]      = idx;
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    // R7
    winner_src_live_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb[t].take |-> (srcValid[win[t]] && srcTid[win[t]] == TID_W'(t)));
    // R5
    winner_older_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb[t].take |-> (srcSeq[win[t]] < marker[t]));
  end
endmodule

// File: rtl/redirect_filter_dp.sv
module redirect_filter_dp
  import redirect_filter_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int NUM_SRC     = 3,
  parameter int SEQ_W       = 16,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t [NUM_THREADS-1:0]           stb,
  input  logic [NUM_THREADS-1:0][IDX_W-1:0]   win,
  input  logic [NUM_SRC-1:0][SEQ_W-1:0]       srcSeq,
  input  logic [NUM_SRC-1:0]                  srcMispred,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0]      srcTarget,
  input  logic [NUM_THREADS-1:0][SEQ_W-1:0]   insSeq,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]   marker,
  output logic [NUM_THREADS-1:0]              sqValid,
  output logic [NUM_THREADS-1:0][SEQ_W-1:0]   sqSeq,
  output logic [NUM_THREADS-1:0]              sqMispred,
  output logic [NUM_THREADS-1:0][ADDR_W-1:0]  sqTarget
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        marker[t]    <= '0;
        sqValid[t]   <= 1'b0;
        sqSeq[t]     <= '0;
        sqMispred[t] <= 1'b0;
        sqTarget[t]  <= '0;
      end else begin
        sqValid[t] <= stb[t].take;
        if (stb[t].take) begin
          marker[t]    <= srcSeq[win[t]];
          sqSeq[t]     <= srcSeq[win[t]];
          sqMispred[t] <= srcMispred[win[t]];
          sqTarget[t]  <= srcTarget[win[t]];
        end else if (stb[t].bump) begin
          marker[t] <= insSeq[t];
        end
      end
    end

    // R4
    bcast_older_chk: assert property (@(posedge clk) disable iff (!rstN)
      sqValid[t] |-> (sqSeq[t] < $past(marker[t])));
    // R6
    marker_pulled_chk: assert property (@(posedge clk) disable iff (!rstN)
      sqValid[t] |-> (marker[t] == sqSeq[t]));
    // R3
    marker_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(stb[t].bump) && !$past(stb[t].take)) |-> $stable(marker[t]));
    // R2
    marker_bump_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(stb[t].bump) |-> (marker[t] == $past(insSeq[t])));
  end
endmodule

// File: rtl/redirect_filter.sv
module redirect_filter
  import redirect_filter_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int NUM_SRC     = 3,
  parameter int SEQ_W       = 16,
  parameter int ADDR_W      = 32,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_THREADS-1:0]        insValid,
  input  logic [NUM_THREADS*SEQ_W-1:0]  insSeq,
  input  logic [NUM_SRC-1:0]            srcValid,
  input  logic [NUM_SRC*TID_W-1:0]      srcTid,
  input  logic [NUM_SRC*SEQ_W-1:0]      srcSeq,
  input  logic [NUM_SRC-1:0]            srcMispred,
  input  logic [NUM_SRC*ADDR_W-1:0]     srcTarget,
  output logic [NUM_THREADS-1:0]        sqValid,
  output logic [NUM_THREADS*SEQ_W-1:0]  sqSeq,
  output logic [NUM_THREADS-1:0]        sqMispred,
  output logic [NUM_THREADS*ADDR_W-1:0] sqTarget,
  output logic [NUM_THREADS*SEQ_W-1:0]  youngSeq
);
  logic [NUM_SRC-1:0][TID_W-1:0]       tidA;
  logic [NUM_SRC-1:0][SEQ_W-1:0]       seqA;
  logic [NUM_SRC-1:0][ADDR_W-1:0]      tgtA;
  logic [NUM_THREADS-1:0][SEQ_W-1:0]   insA;
  logic [NUM_THREADS-1:0][SEQ_W-1:0]   markerA;
  logic [NUM_THREADS-1:0][SEQ_W-1:0]   sqSeqA;
  logic [NUM_THREADS-1:0][ADDR_W-1:0]  sqTgtA;
  strobe_t [NUM_THREADS-1:0]           stb;
  logic [NUM_THREADS-1:0][IDX_W-1:0]   win;

  assign tidA     = srcTid;
  assign seqA     = srcSeq;
  assign tgtA     = srcTarget;
  assign insA     = insSeq;
  assign sqSeq    = sqSeqA;
  assign sqTarget = sqTgtA;
  assign youngSeq = markerA;

  redirect_filter_ctrl #(
    .NUM_THREADS(NUM_THREADS), .NUM_SRC(NUM_SRC), .SEQ_W(SEQ_W),
    .TID_W(TID_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcTid(tidA),
    .srcSeq(seqA), .insValid(insValid), .insSeq(insA), .marker(markerA),
    .stb(stb), .win(win)
  );

  redirect_filter_dp #(
    .NUM_THREADS(NUM_THREADS), .NUM_SRC(NUM_SRC), .SEQ_W(SEQ_W),
    .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .win(win), .srcSeq(seqA),
    .srcMispred(srcMispred), .srcTarget(tgtA), .insSeq(insA),
    .marker(markerA), .sqValid(sqValid), .sqSeq(sqSeqA),
    .sqMispred(sqMispred), .sqTarget(sqTgtA)
  );
endmodule

// File: tb/redirect_filter_bench.sv
module redirect_filter_bench;
  localparam int NT = 2, NS = 3, SW = 16, AW = 32, TW = 1;

  logic clk = 0, rstN = 0;
  logic [NT-1:0]    insValid;
  logic [NT*SW-1:0] insSeq;
  logic [NS-1:0]    srcValid;
  logic [NS*TW-1:0] srcTid;
  logic [NS*SW-1:0] srcSeq;
  logic [NS-1:0]    srcMispred;
  logic [NS*AW-1:0] srcTarget;
  logic [NT-1:0]    sqValid;
  logic [NT*SW-1:0] sqSeq;
  logic [NT-1:0]    sqMispred;
  logic [NT*AW-1:0] sqTarget;
  logic [NT*SW-1:0] youngSeq;

  int total = 0, bad = 0;
  logic [SW-1:0] mk [NT];

  always #5 clk = ~clk;

  redirect_filter u_redirect_filter (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insSeq(insSeq),
    .srcValid(srcValid), .srcTid(srcTid), .srcSeq(srcSeq),
    .srcMispred(srcMispred), .srcTarget(srcTarget), .sqValid(sqValid),
    .sqSeq(sqSeq), .sqMispred(sqMispred), .sqTarget(sqTarget),
    .youngSeq(youngSeq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    insValid = '0; insSeq = '0; srcValid = '0; srcTid = '0;
    srcSeq = '0; srcMispred = '0; srcTarget = '0;
  endtask

  task automatic setSrc(int s, int tid, int seq, bit mp, int tgt);
    srcValid[s] = 1'b1;
    srcTid[s*TW +: TW] = TW'(tid);
    srcSeq[s*SW +: SW] = SW'(seq);
    srcMispred[s] = mp;
    srcTarget[s*AW +: AW] = AW'(tgt);
  endtask

  task automatic setIns(int t, int seq);
    insValid[t] = 1'b1;
    insSeq[t*SW +: SW] = SW'(seq);
  endtask

  // inputs already driven at a falling edge; predict, step one cycle, compare
  task automatic cycle(string tagB, string tagM);
    bit            expV  [NT];
    logic [SW-1:0] expS  [NT];
    bit            expMp [NT];
    logic [AW-1:0] expTg [NT];
    for (int t = 0; t < NT; t++) begin
      expV[t] = 0; expS[t] = '1; expMp[t] = 0; expTg[t] = '0;
      for (int s = 0; s < NS; s++) begin
        if (srcValid[s] && int'(srcTid[s*TW +: TW]) == t &&
            srcSeq[s*SW +: SW] < mk[t] &&
            (!expV[t] || srcSeq[s*SW +: SW] < expS[t])) begin
          expV[t]  = 1;
          expS[t]  = srcSeq[s*SW +: SW];
          expMp[t] = srcMispred[s];
          expTg[t] = srcTarget[s*AW +: AW];
        end
      end
      if (expV[t]) mk[t] = expS[t];
      else if (insValid[t] && insSeq[t*SW +: SW] > mk[t]) mk[t] = insSeq[t*SW +: SW];
    end
    @(posedge clk);
    @(negedge clk);
    for (int t = 0; t < NT; t++) begin
      chk(tagB, 64'(sqValid[t]), 64'(expV[t]));
      if (expV[t]) begin
        chk(tagB, 64'(sqSeq[t*SW +: SW]), 64'(expS[t]));
        chk(tagB, 64'(sqMispred[t]), 64'(expMp[t]));
        chk(tagB, 64'(sqTarget[t*AW +: AW]), 64'(expTg[t]));
      end
      chk(tagM, 64'(youngSeq[t*SW +: SW]), 64'(mk[t]));
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    idle();
    for (int t = 0; t < NT; t++) mk[t] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", 64'(sqValid), 64'(0));
    chk("R1", 64'(youngSeq), 64'(0));

    // R2 inserts advance markers
    idle(); setIns(0, 100); setIns(1, 50); cycle("R2", "R2");
    // R3 smaller insert ignored
    idle(); setIns(0, 80); cycle("R3", "R3");
    // R5 equal or younger redirects dropped
    idle(); setSrc(0, 0, 100, 1, 32'h1000); setSrc(1, 1, 60, 0, 32'h2000);
    cycle("R5", "R5");
    // R7 oldest wins, tie to lowest index; R6 squash beats insert
    idle(); setSrc(0, 0, 90, 1, 32'hA0); setSrc(1, 0, 70, 0, 32'hB0);
    setSrc(2, 0, 70, 1, 32'hC0); setIns(0, 200);
    cycle("R7", "R6");
    // R9 single-cycle pulse
    idle(); cycle("R9", "R9");
    // R8 both threads in one cycle
    idle(); setSrc(0, 1, 10, 1, 32'h11); setSrc(1, 0, 20, 0, 32'h22);
    cycle("R8", "R8");
    // R8 per-thread marker: 15 older than t0 marker 20, not t1 marker 10
    idle(); setSrc(0, 0, 15, 1, 32'h33); setSrc(2, 1, 15, 1, 32'h44);
    cycle("R8", "R8");
    // R4 mispred and target carried
    idle(); setIns(1, 300); cycle("R2", "R2");
    idle(); setSrc(1, 1, 299, 1, 32'hDEADBEEF); cycle("R4", "R4");

    for (int i = 0; i < 3000; i++) begin
      idle();
      for (int t = 0; t < NT; t++)
        if ($urandom % 3 == 0) setIns(t, int'(mk[t]) + int'($urandom % 20) - 4);
      for (int s = 0; s < NS; s++)
        if ($urandom % 2 == 0) begin
          int tid;
          tid = int'($urandom % NT);
          setSrc(s, tid, int'(mk[tid]) - 12 + int'($urandom % 16),
                 1'($urandom), int'($urandom));
        end
      cycle("R4", "R2");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule